// File: doc/BRIEF.md
# DMA control byte sequencer

This block sits behind the one write port that a CPU uses to program a DMA controller. Every byte written to that port arrives here as a strobe and an 8-bit value. When nothing is outstanding, the block treats the byte as a header and sorts it into a register group by fixed bit patterns. It then looks at that header's flag bits to learn which parameter bytes will follow. Those bytes are steered, in a fixed order, into port addresses, block length, timing bytes or interrupt control. When a parameter's flag is clear, its byte is not sent and the register keeps its value.

Command headers are not stored. Each one becomes a single-cycle strobe for the transfer engine. The enable command and the disable command also set and clear a held enable state. The reset command turns the enable state off and puts both port timing bytes back to their default. The transfer engine and any read-back path lie outside this block. They consume the outputs listed below.

Top module: `dma_cfg_decoder`

## Requirements
- R1: After reset, the address outputs, block length, interrupt control, operation, direction, port step modes, I/O flags, transfer mode and end-of-block flags are all zero. Both timing outputs equal DEF_TIMING (default 8'hCC). The enable state is off and no command strobe is high.
- R2: When no parameter byte is pending, a byte with bit 7 = 0 and bits 1-0 not 00 is a transfer header. Bits 1-0 go to `op_kind` (01 transfer, 10 search, 11 search and transfer). Bit 2 goes to `dir_a_to_b` (1 means A to B).
- R3: In a transfer header, flag bits 3, 4, 5 and 6 announce follow-on bytes. They arrive in this order: port A address low, port A address high, block length low, block length high. A byte whose flag is clear is skipped, and its register keeps its old value.
- R4: When no parameter byte is pending, bit 7 = 0 with bits 2-0 = 100 selects the port A header, and bits 2-0 = 000 selects the port B header. Bits 5-4 set the step mode (00 down, 01 up, 10/11 fixed). Bit 3 sets the I/O flag (1 = I/O). Bit 6 announces one timing byte for that port, which is stored whole.
- R5: When no parameter byte is pending, bit 7 = 1 with bits 1-0 = 01 is the mode header. Bits 6-5 set `xfer_mode` (00 byte, 01 continuous, 10 burst). The value 11 leaves `xfer_mode` unchanged. Flag bits 2, 3 and 4 announce, in that order, port B address low, port B address high and interrupt control.
- R6: When no parameter byte is pending, bits 7-6 = 10 with bits 2-0 = 010 is the end-of-block header. Bit 5 sets `auto_restart`, bit 4 sets `ce_wait_mux`, and bit 3 sets `ready_high`.
- R7: While a flagged byte is still outstanding, every written byte is stored as the next parameter, whatever its bit pattern. Such a byte raises no command strobe and changes no enable state.
- R8: When no parameter byte is pending, the command bytes raise exactly one matching strobe for exactly one cycle: CF load, D3 continue, B3 force ready, AB interrupts on, AF interrupts off.
- R9: Command 87 raises `cmd_enable` and sets `dma_enabled`. Command 83 raises `cmd_disable` and clears `dma_enabled`.
- R10: Command C3 raises `cmd_reset`, clears `dma_enabled` and restores both timing bytes to DEF_TIMING. Command C7 restores only the port A timing, and CB restores only the port B timing.
- R11: Command-pattern bytes (bit 7 = 1, bits 1-0 = 11) with an unlisted code, bytes with bit 7 = 1 and bits 1-0 = 00, and bytes with bits 7-6 = 11 and bits 1-0 = 10 change no output and raise no strobe.
- R12: Exactly one byte is taken per clock with `wr_en` high. With `wr_en` low, no stored output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Written byte |
| op_kind | output | 2 | Operation from the transfer header |
| dir_a_to_b | output | 1 | Direction, 1 = A to B |
| port_a_addr | output | 16 | Port A start address |
| block_len | output | 16 | Block length |
| a_step | output | 2 | Port A address step mode |
| a_is_io | output | 1 | Port A is I/O |
| a_timing | output | 8 | Port A timing byte |
| b_step | output | 2 | Port B address step mode |
| b_is_io | output | 1 | Port B is I/O |
| b_timing | output | 8 | Port B timing byte |
| port_b_addr | output | 16 | Port B start address |
| xfer_mode | output | 2 | Byte, continuous or burst |
| int_ctrl | output | 8 | Interrupt control byte |
| auto_restart | output | 1 | Restart at end of block |
| ce_wait_mux | output | 1 | Chip-enable/wait sharing |
| ready_high | output | 1 | Ready input active high |
| dma_enabled | output | 1 | Held enable state |
| cmd_reset | output | 1 | Reset command strobe |
| cmd_load | output | 1 | Load command strobe |
| cmd_continue | output | 1 | Continue command strobe |
| cmd_force_ready | output | 1 | Force ready strobe |
| cmd_enable | output | 1 | Enable command strobe |
| cmd_disable | output | 1 | Disable command strobe |
| cmd_int_on | output | 1 | Interrupt enable strobe |
| cmd_int_off | output | 1 | Interrupt disable strobe |

## Verification
The bench sends a parameter byte equal to the enable code while a header is still waiting for bytes. A design that decodes headers too early would raise the enable state and drop the address byte, and the bench would see both. Headers with only some flags set check that skipped bytes keep their old values. A design that assumed a fixed byte count would load the wrong fields. Reserved mode value 11, unlisted command codes and stray header patterns must leave every output alone. The single-port timing resets must touch only their own port, so a design that mixed them up would corrupt the other timing byte.

// File: rtl/dma_cfg_decoder.sv
module dma_cfg_decoder #(
  parameter logic [7:0] DEF_TIMING = 8'hCC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [1:0]  op_kind,
  output logic        dir_a_to_b,
  output logic [15:0] port_a_addr,
  output logic [15:0] block_len,
  output logic [1:0]  a_step,
  output logic        a_is_io,
  output logic [7:0]  a_timing,
  output logic [1:0]  b_step,
  output logic        b_is_io,
  output logic [7:0]  b_timing,
  output logic [15:0] port_b_addr,
  output logic [1:0]  xfer_mode,
  output logic [7:0]  int_ctrl,
  output logic        auto_restart,
  output logic        ce_wait_mux,
  output logic        ready_high,
  output logic        dma_enabled,
  output logic        cmd_reset,
  output logic        cmd_load,
  output logic        cmd_continue,
  output logic        cmd_force_ready,
  output logic        cmd_enable,
  output logic        cmd_disable,
  output logic        cmd_int_on,
  output logic        cmd_int_off
);

  localparam logic [1:0] PG_XFER = 2'd0;
  localparam logic [1:0] PG_A    = 2'd1;
  localparam logic [1:0] PG_B    = 2'd2;
  localparam logic [1:0] PG_MODE = 2'd3;

  logic [3:0] pend;
  logic [1:0] pgrp;

  wire       busy  = |pend;
  wire [3:0] slot  = pend & (~pend + 4'd1);
  wire       param = wr_en && busy;
  wire       hdr   = wr_en && !busy;
  wire [7:0] d     = wr_data;

  wire is_xfer = hdr && !d[7] && (d[1:0] != 2'b00);
  wire is_a    = hdr && !d[7] && (d[2:0] == 3'b100);
  wire is_b    = hdr && !d[7] && (d[2:0] == 3'b000);
  wire is_mode = hdr && d[7] && (d[1:0] == 2'b01);
  wire is_eob  = hdr && (d[7:6] == 2'b10) && (d[2:0] == 3'b010);
  wire is_cmd  = hdr && d[7] && (d[1:0] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; pgrp <= PG_XFER;
      op_kind <= '0; dir_a_to_b <= 1'b0;
      port_a_addr <= '0; block_len <= '0; port_b_addr <= '0;
      a_step <= '0; a_is_io <= 1'b0; a_timing <= DEF_TIMING;
      b_step <= '0; b_is_io <= 1'b0; b_timing <= DEF_TIMING;
      xfer_mode <= '0; int_ctrl <= '0;
      auto_restart <= 1'b0; ce_wait_mux <= 1'b0; ready_high <= 1'b0;
      dma_enabled <= 1'b0;
      {cmd_reset, cmd_load, cmd_continue, cmd_force_ready,
       cmd_enable, cmd_disable, cmd_int_on, cmd_int_off} <= '0;
    end else begin
      {cmd_reset, cmd_load, cmd_continue, cmd_force_ready,
       cmd_enable, cmd_disable, cmd_int_on, cmd_int_off} <= '0;

      if (param) begin
        pend <= pend & ~slot;
        case (pgrp)
          PG_XFER:
            case (slot)
              4'b0001: port_a_addr[7:0]  <= d;
              4'b0010: port_a_addr[15:8] <= d;
              4'b0100: block_len[7:0]    <= d;
              4'b1000: block_len[15:8]   <= d;
              default: ;
            endcase
          PG_A: a_timing <= d;
          PG_B: b_timing <= d;
          PG_MODE:
            case (slot)
              4'b0001: port_b_addr[7:0]  <= d;
              4'b0010: port_b_addr[15:8] <= d;
              4'b0100: int_ctrl          <= d;
              default: ;
            endcase
          default: ;
        endcase
      end

      if (is_xfer) begin
        op_kind <= d[1:0]; dir_a_to_b <= d[2];
        pend <= d[6:3]; pgrp <= PG_XFER;
      end
      if (is_a) begin
        a_step <= d[5:4]; a_is_io <= d[3];
        pend <= {3'b000, d[6]}; pgrp <= PG_A;
      end
      if (is_b) begin
        b_step <= d[5:4]; b_is_io <= d[3];
        pend <= {3'b000, d[6]}; pgrp <= PG_B;
      end
      if (is_mode) begin
        if (d[6:5] != 2'b11) xfer_mode <= d[6:5];
        pend <= {1'b0, d[4:2]}; pgrp <= PG_MODE;
      end
      if (is_eob) begin
        auto_restart <= d[5]; ce_wait_mux <= d[4]; ready_high <= d[3];
      end
      if (is_cmd) begin
        case (d)
          8'hC3: begin
            cmd_reset <= 1'b1; dma_enabled <= 1'b0;
            a_timing <= DEF_TIMING; b_timing <= DEF_TIMING;
          end
          8'hC7: a_timing <= DEF_TIMING;
          8'hCB: b_timing <= DEF_TIMING;
          8'hCF: cmd_load <= 1'b1;
          8'hD3: cmd_continue <= 1'b1;
          8'hB3: cmd_force_ready <= 1'b1;
          8'hAB: cmd_int_on <= 1'b1;
          8'hAF: cmd_int_off <= 1'b1;
          8'h87: begin cmd_enable <= 1'b1; dma_enabled <= 1'b1; end
          8'h83: begin cmd_disable <= 1'b1; dma_enabled <= 1'b0; end
          default: ;
        endcase
      end
    end
  end

  wire [7:0] strobes = {cmd_reset, cmd_load, cmd_continue, cmd_force_ready,
                        cmd_enable, cmd_disable, cmd_int_on, cmd_int_off};

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes) && !wr_en |=> !(|strobes));

  assert_param_no_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> (strobes == 8'h00) && $stable(dma_enabled));

  assert_enable_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_enabled) |-> cmd_enable);

  assert_reset_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |-> !dma_enabled && a_timing == DEF_TIMING && b_timing == DEF_TIMING);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(port_a_addr) && $stable(block_len) && $stable(port_b_addr)
               && $stable(xfer_mode) && $stable(dma_enabled) && $stable(int_ctrl));

endmodule

// File: tb/dma_cfg_decoder_test.sv
module dma_cfg_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;

  logic [1:0]  op_kind, a_step, b_step, xfer_mode;
  logic        dir_a_to_b, a_is_io, b_is_io, auto_restart, ce_wait_mux, ready_high, dma_enabled;
  logic [15:0] port_a_addr, block_len, port_b_addr;
  logic [7:0]  a_timing, b_timing, int_ctrl;
  logic        cmd_reset, cmd_load, cmd_continue, cmd_force_ready;
  logic        cmd_enable, cmd_disable, cmd_int_on, cmd_int_off;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_cfg_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .op_kind(op_kind), .dir_a_to_b(dir_a_to_b), .port_a_addr(port_a_addr),
    .block_len(block_len), .a_step(a_step), .a_is_io(a_is_io), .a_timing(a_timing),
    .b_step(b_step), .b_is_io(b_is_io), .b_timing(b_timing), .port_b_addr(port_b_addr),
    .xfer_mode(xfer_mode), .int_ctrl(int_ctrl), .auto_restart(auto_restart),
    .ce_wait_mux(ce_wait_mux), .ready_high(ready_high), .dma_enabled(dma_enabled),
    .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_continue(cmd_continue),
    .cmd_force_ready(cmd_force_ready), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_int_on(cmd_int_on), .cmd_int_off(cmd_int_off)
  );

  wire [7:0] strobes = {cmd_reset, cmd_load, cmd_continue, cmd_force_ready,
                        cmd_enable, cmd_disable, cmd_int_on, cmd_int_off};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset_state;
    chk("R1 addrs", {port_a_addr, port_b_addr}, 32'h0);
    chk("R1 len", {16'h0, block_len}, 32'h0);
    chk("R1 timings", {16'h0, a_timing, b_timing}, 32'h0000CCCC);
    chk("R1 misc", {op_kind, dir_a_to_b, a_step, a_is_io, b_step, b_is_io, xfer_mode,
                    int_ctrl, auto_restart, ce_wait_mux, ready_high, dma_enabled}, 32'h0);
    chk("R1 strobes", {24'h0, strobes}, 32'h0);
  endtask

  task automatic t_xfer_full;
    send(8'h7D); send(8'h00); send(8'hC0); send(8'h00); send(8'h1B);
    chk("R2 op", {30'h0, op_kind}, 32'd1);
    chk("R2 dir", {31'h0, dir_a_to_b}, 32'd1);
    chk("R3 addr A", {16'h0, port_a_addr}, 32'h0000C000);
    chk("R3 len", {16'h0, block_len}, 32'h00001B00);
  endtask

  task automatic t_xfer_partial;
    send(8'h56); send(8'h87); send(8'h22);
    chk("R2 op search", {30'h0, op_kind}, 32'd2);
    chk("R3 skipped low kept", {16'h0, port_a_addr}, 32'h00008700);
    chk("R3 len high only", {16'h0, block_len}, 32'h00002200);
    chk("R7 param not cmd", {31'h0, dma_enabled}, 32'd0);
    send(8'h01);
    chk("R2 dir B to A", {30'h0, dir_a_to_b, op_kind[0]}, 32'd1);
  endtask

  task automatic t_ports;
    send(8'h54); send(8'hCE);
    chk("R4 A step/io", {29'h0, a_step, a_is_io}, 32'b010);
    chk("R4 A timing", {24'h0, a_timing}, 32'hCE);
    send(8'h28);
    chk("R4 B step/io", {29'h0, b_step, b_is_io}, 32'b101);
    chk("R4 B timing kept", {24'h0, b_timing}, 32'hCC);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hCF;
    @(negedge clk); wr_en = 1'b0;
    chk("R4 nothing pending after B", {24'h0, strobes}, 32'h40);
  endtask

  task automatic t_mode;
    send(8'hDD); send(8'h00); send(8'h40); send(8'h5A);
    chk("R5 burst", {30'h0, xfer_mode}, 32'd2);
    chk("R5 B addr", {16'h0, port_b_addr}, 32'h4000);
    chk("R5 int ctrl", {24'h0, int_ctrl}, 32'h5A);
    send(8'hE5); send(8'h34);
    chk("R5 mode 11 kept", {30'h0, xfer_mode}, 32'd2);
    chk("R5 B low only", {16'h0, port_b_addr}, 32'h4034);
    chk("R5 int kept", {24'h0, int_ctrl}, 32'h5A);
  endtask

  task automatic t_eob;
    send(8'hBA);
    chk("R6 all set", {29'h0, auto_restart, ce_wait_mux, ready_high}, 32'b111);
    send(8'hA2);
    chk("R6 restart only", {29'h0, auto_restart, ce_wait_mux, ready_high}, 32'b100);
  endtask

  task automatic t_cmds;
    logic [7:0] codes [5] = '{8'hCF, 8'hD3, 8'hB3, 8'hAB, 8'hAF};
    logic [7:0] exp   [5] = '{8'h40, 8'h20, 8'h10, 8'h02, 8'h01};
    for (int i = 0; i < 5; i++) begin
      send(codes[i]);
      chk("R8 strobe", {24'h0, strobes}, {24'h0, exp[i]});
      @(negedge clk);
      chk("R8 strobe one cycle", {24'h0, strobes}, 32'h0);
    end
  endtask

  task automatic t_enable;
    send(8'h87);
    chk("R9 enable strobe", {24'h0, strobes}, 32'h08);
    chk("R9 enabled", {31'h0, dma_enabled}, 32'd1);
    send(8'h83);
    chk("R9 disable strobe", {24'h0, strobes}, 32'h04);
    chk("R9 disabled", {31'h0, dma_enabled}, 32'd0);
  endtask

  task automatic t_timing_reset;
    send(8'h68); send(8'h0E);
    chk("R10 B timing set", {24'h0, b_timing}, 32'h0E);
    send(8'hC7);
    chk("R10 C7 A only", {16'h0, a_timing, b_timing}, 32'hCC0E);
    send(8'h54); send(8'h4D);
    send(8'hCB);
    chk("R10 CB B only", {16'h0, a_timing, b_timing}, 32'h4DCC);
    send(8'h68); send(8'h0E);
    send(8'h87);
    send(8'hC3);
    chk("R10 reset strobe", {24'h0, strobes}, 32'h80);
    chk("R10 reset state", {15'h0, dma_enabled, a_timing, b_timing}, 32'h0000CCCC);
  endtask

  task automatic t_ignored;
    send(8'h87);
    send(8'hBF);
    chk("R11 unlisted cmd no strobe", {24'h0, strobes}, 32'h0);
    send(8'h80);
    chk("R11 group3 no strobe", {24'h0, strobes}, 32'h0);
    send(8'hFE);
    chk("R11 stray no strobe", {24'h0, strobes}, 32'h0);
    chk("R11 regs kept", {port_a_addr, port_b_addr}, 32'h87004034);
    chk("R11 state kept", {27'h0, dma_enabled, xfer_mode, op_kind[0], dir_a_to_b}, 32'b11010);
    send(8'h83);
  endtask

  task automatic t_idle;
    @(negedge clk); wr_data = 8'h87;
    repeat (3) @(negedge clk);
    chk("R12 no strobe no change", {23'h0, dma_enabled, strobes}, 32'h0);
    wr_data = 8'h00;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_xfer_full();
    t_xfer_partial();
    t_ports();
    t_mode();
    t_eob();
    t_cmds();
    t_enable();
    t_timing_reset();
    t_ignored();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule